// File: doc/BRIEF.md
# Write-Only Two-Wire Command Receiver

This block is a target on a two-wire serial bus (I2C) that accepts only write transactions. It samples the open-drain clock and data lines with the system clock and recognises START, repeated START and STOP conditions. It checks the 7-bit target address that follows a START. Each transaction that is addressed to it and marked as a write yields a single 24-bit command word. The block answers two addresses. One is chosen by a three-level address pin, and the other is a fixed broadcast address shared by every receiver on the bus.

The block acknowledges the address byte and then exactly three data bytes. When the third byte completes, it presents the assembled word on `word_o` with a one-cycle strobe, so the command logic downstream can act on it. It refuses read requests, bytes addressed elsewhere, and any byte after the third. The bus controller drives the line level from `sda_pull_o`, which only ever pulls the data line low. The system clock must run at least 16 times faster than the bus clock, whose rate is up to 400 kHz.

Top module: `i2c_cmd_receiver`

## Requirements
- R1: A falling data line while the clock line is high starts a transaction. A rising data line while the clock is high ends it. After a STOP, no byte is acknowledged until a new START.
- R2: The pin-selected address follows `addr_sel_i`: 2'b00 (ground) gives 7'h10, 2'b01 (open) gives 7'h11, 2'b10 (supply) gives 7'h12. The code 2'b11 selects no pin address.
- R3: The broadcast address 7'h73 is acknowledged for every value of `addr_sel_i`.
- R4: An address byte whose least significant (direction) bit is 1, a read, is never acknowledged, even when the address matches. No byte that follows it in the same transaction is acknowledged.
- R5: An acknowledge holds the data line low for the whole high period of the 9th clock. The target starts pulling only on the clock falling edge that ends the 8th bit and releases on the falling edge that ends the 9th.
- R6: Bits are taken MSB first on clock rising edges. After a matching write address, the first three data bytes are acknowledged. The third one causes one `word_vld_o` pulse, one cycle wide, with the first byte in `word_o[23:16]` and the third in `word_o[7:0]`.
- R7: A data byte after the third in the same transaction is not acknowledged, raises no strobe, and leaves `word_o` unchanged.
- R8: A STOP or repeated START before the third data byte completes discards the partial word. A transaction that follows a repeated START is decoded from its own address byte.
- R9: An address that matches neither the selected nor the broadcast address is not acknowledged, and neither is any byte after it.
- R10: After reset, `sda_pull_o` and `word_vld_o` are 0 and `word_o` is all zeros.
- R11: A clock-line pulse one system clock long is filtered out and adds no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed bus clock line level |
| sda_i | input | 1 | Sensed bus data line level |
| addr_sel_i | input | 2 | Address pin level: 00 ground, 01 open, 10 supply, 11 none |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |
| word_o | output | 24 | Last complete command word, first byte in [23:16] |
| word_vld_o | output | 1 | One-cycle strobe marking a new `word_o` |

## Verification
The checker watches, on every cycle, the timing of the acknowledge drive. The pull starts only after a clock falling edge and ends on the falling edge that closes the 9th clock. It never changes while the filtered clock is high, and it is released after a STOP. The checker also holds the strobe to one cycle, coinciding with the third acknowledge. The bench scenarios cover the rest, which depends on whole byte sequences: which address and direction combinations are acknowledged, the refusal of a fourth byte, the discarding of partial words on STOP or repeated START, the byte order in the word, and the rejection of clock glitches.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR     = 3'd1,
    ST_ADDR_ACK = 3'd2,
    ST_DATA     = 3'd3,
    ST_DATA_ACK = 3'd4,
    ST_REFUSE   = 3'd5
  } rx_state_t;

  // Three-level pin code to {valid, address}; 2'b11 selects nothing.
  function automatic logic [7:0] pin_addr(input logic [1:0] sel, input logic [6:0] base);
    case (sel)
      2'b00:   pin_addr = {1'b1, base};
      2'b01:   pin_addr = {1'b1, 7'(base + 7'd1)};
      2'b10:   pin_addr = {1'b1, 7'(base + 7'd2)};
      default: pin_addr = {1'b0, base};
    endcase
  endfunction

  // Strict majority over the lowest n bits of v.
  function automatic logic vote(input logic [15:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < 16; i++)
      if (i < n && v[i]) c++;
    vote = (2 * c > n);
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  import i2c_cmd_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= vote(16'(win_q), FILT_TAPS);
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_frame_fsm.sv
module i2c_frame_fsm #(
  parameter int         WORD_BYTES = 3,
  parameter logic [6:0] BASE_ADDR  = 7'h10,
  parameter logic [6:0] BCAST_ADDR = 7'h73,
  localparam int        WORD_W     = 8 * WORD_BYTES,
  localparam int        CNT_W      = $clog2(WORD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [1:0]        addr_sel,
  output logic              sda_pull,
  output logic [WORD_W-1:0] word,
  output logic              word_vld,
  output logic              ack_phase,
  output logic              addr_hit
);
  import i2c_cmd_pkg::*;

  rx_state_t         state;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg;
  logic [CNT_W-1:0]  byte_cnt;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_next;
  logic [7:0]        own;
  logic              is_write;
  logic              byte_end;

  assign own      = pin_addr(addr_sel, BASE_ADDR);
  assign addr_hit = (own[7] && shreg[7:1] == own[6:0]) || (shreg[7:1] == BCAST_ADDR);
  assign is_write = ~shreg[0];
  assign acc_next = WORD_W'({acc, shreg});
  assign byte_end = scl_fall && (bit_cnt == 4'd8);
  assign ack_phase = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_cnt <= '0;
      acc      <= '0;
      word     <= '0;
      word_vld <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (start_ev) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        byte_cnt <= '0;
        sda_pull <= 1'b0;
      end else if (stop_ev) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_end) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit && is_write) begin
                  sda_pull <= 1'b1;
                  state    <= ST_ADDR_ACK;
                end else begin
                  state    <= ST_REFUSE;
                end
              end else if (byte_cnt < CNT_W'(WORD_BYTES)) begin
                sda_pull <= 1'b1;
                state    <= ST_DATA_ACK;
                acc      <= acc_next;
                byte_cnt <= byte_cnt + 1'b1;
                if (byte_cnt == CNT_W'(WORD_BYTES - 1)) begin
                  word     <= acc_next;
                  word_vld <= 1'b1;
                end
              end else begin
                state <= ST_REFUSE;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_receiver.sv
module i2c_cmd_receiver #(
  parameter int         WORD_BYTES  = 3,
  parameter logic [6:0] BASE_ADDR   = 7'h10,
  parameter logic [6:0] BCAST_ADDR  = 7'h73,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_TAPS   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [1:0]  addr_sel_i,
  output logic        sda_pull_o,
  output logic [23:0] word_o,
  output logic        word_vld_o
);
  localparam int WORD_W = 8 * WORD_BYTES;

  logic [1:0] raw_lines;
  logic [1:0] filt_lines;
  logic       filt_scl_w, filt_sda_w;
  logic       scl_rise_w, scl_fall_w, start_w, stop_w;
  logic       ack_phase_w, addr_hit_w;
  logic [WORD_W-1:0] word_w;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_TAPS  (FILT_TAPS)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign filt_scl_w = filt_lines[0];
  assign filt_sda_w = filt_lines[1];

  i2c_bus_events u_ev (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl     (filt_scl_w),
    .sda     (filt_sda_w),
    .scl_rise(scl_rise_w),
    .scl_fall(scl_fall_w),
    .start_ev(start_w),
    .stop_ev (stop_w)
  );

  i2c_frame_fsm #(
    .WORD_BYTES(WORD_BYTES),
    .BASE_ADDR (BASE_ADDR),
    .BCAST_ADDR(BCAST_ADDR)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda      (filt_sda_w),
    .scl_rise (scl_rise_w),
    .scl_fall (scl_fall_w),
    .start_ev (start_w),
    .stop_ev  (stop_w),
    .addr_sel (addr_sel_i),
    .sda_pull (sda_pull_o),
    .word     (word_w),
    .word_vld (word_vld_o),
    .ack_phase(ack_phase_w),
    .addr_hit (addr_hit_w)
  );

  assign word_o = 24'(word_w);
endmodule

// File: rtl/i2c_cmd_receiver_chk.sv
module i2c_cmd_receiver_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_pull_o,
  input logic word_vld_o,
  input logic filt_scl_w,
  input logic scl_fall_w,
  input logic start_w,
  input logic stop_w,
  input logic ack_phase_w
);
  a_r5_steady_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_scl_w && $past(filt_scl_w)) |-> $stable(sda_pull_o));

  a_r5_pull_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall_w));

  a_r5_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o && scl_fall_w) |=> !sda_pull_o);

  a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

  a_r6_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |-> $rose(sda_pull_o));

  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_w |=> (!sda_pull_o && !ack_phase_w));

  a_r8_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> !sda_pull_o);
endmodule

bind i2c_cmd_receiver i2c_cmd_receiver_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_pull_o (sda_pull_o),
  .word_vld_o (word_vld_o),
  .filt_scl_w (filt_scl_w),
  .scl_fall_w (scl_fall_w),
  .start_w    (start_w),
  .stop_w     (stop_w),
  .ack_phase_w(ack_phase_w)
);

// File: tb/sim_i2c_cmd_receiver.sv
`timescale 1ns/1ps
module sim_i2c_cmd_receiver;
  localparam int H = 40;  // system clocks per bus clock phase

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_drv = 1'b1;
  logic        sda_drv = 1'b1;
  logic [1:0]  addr_sel = 2'b00;
  logic        sda_pull_o;
  logic [23:0] word_o;
  logic        word_vld_o;
  logic        sda_line;
  logic        done = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  logic [23:0] exp_q[$];

  always #2.5 clk = ~clk;

  assign sda_line = sda_drv & ~sda_pull_o;

  i2c_cmd_receiver u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_drv),
    .sda_i     (sda_line),
    .addr_sel_i(addr_sel),
    .sda_pull_o(sda_pull_o),
    .word_o    (word_o),
    .word_vld_o(word_vld_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: compares each strobe with the next queued word.
  initial begin
    forever begin
      @(negedge clk);
      if (word_vld_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6/R7/R8 unexpected strobe", {8'h0, word_o}, 32'h0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          chk(word_o == e, "R6 word value", {8'h0, word_o}, {8'h0, e});
        end
      end
    end
  end

  task automatic bus_start();
    sda_drv = 1'b1; wait_clks(H / 2);
    scl_drv = 1'b1; wait_clks(H);
    sda_drv = 1'b0; wait_clks(H);
    scl_drv = 1'b0; wait_clks(H / 2);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_clks(H / 2);
    scl_drv = 1'b1; wait_clks(H);
    sda_drv = 1'b1; wait_clks(H);
  endtask

  // Sends one byte; checks the 9th-clock response against exp_ack.
  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req, input bit glitch);
    bit early, late;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i];
      wait_clks(H / 2);
      if (glitch && i == 4) begin
        scl_drv = 1'b1; wait_clks(1); scl_drv = 1'b0;
      end
      wait_clks(H / 2);
      scl_drv = 1'b1; wait_clks(H);
      scl_drv = 1'b0;
    end
    sda_drv = 1'b1;
    wait_clks(H);
    scl_drv = 1'b1;
    wait_clks(2);
    early = ~sda_line;
    wait_clks(H - 4);
    late = ~sda_line;
    wait_clks(2);
    scl_drv = 1'b0;
    chk((early && late) == exp_ack && early == late, req, {30'h0, early, late},
        {30'h0, exp_ack, exp_ack});
    wait_clks(H / 2);
    chk(sda_pull_o == 1'b0, "R5 released after 9th clock", {31'h0, sda_pull_o}, 32'h0);
  endtask

  initial begin
    wait_clks(5);
    chk(sda_pull_o == 1'b0, "R10 pull at reset", {31'h0, sda_pull_o}, 32'h0);
    chk(word_vld_o == 1'b0, "R10 strobe at reset", {31'h0, word_vld_o}, 32'h0);
    chk(word_o == 24'h0, "R10 word at reset", {8'h0, word_o}, 32'h0);
    rst_n = 1'b1;
    wait_clks(10);

    // R2 R6: ground selection, 0x10
    addr_sel = 2'b00;
    bus_start();
    send_byte({7'h10, 1'b0}, 1'b1, "R2 addr 0x10 ground", 1'b0);
    exp_q.push_back(24'hA53C7F);
    send_byte(8'hA5, 1'b1, "R6 byte1", 1'b0);
    send_byte(8'h3C, 1'b1, "R6 byte2", 1'b0);
    send_byte(8'h7F, 1'b1, "R6 byte3", 1'b0);
    bus_stop();
    chk(word_o == 24'hA53C7F, "R6 byte order", {8'h0, word_o}, 32'hA53C7F);

    // R2 R7: open selection, 0x11, fourth byte refused
    addr_sel = 2'b01;
    bus_start();
    send_byte({7'h11, 1'b0}, 1'b1, "R2 addr 0x11 open", 1'b0);
    exp_q.push_back(24'h123456);
    send_byte(8'h12, 1'b1, "R6 byte1", 1'b0);
    send_byte(8'h34, 1'b1, "R6 byte2", 1'b0);
    send_byte(8'h56, 1'b1, "R6 byte3", 1'b0);
    send_byte(8'h99, 1'b0, "R7 fourth byte refused", 1'b0);
    send_byte(8'h55, 1'b0, "R7 fifth byte refused", 1'b0);
    bus_stop();
    chk(word_o == 24'h123456, "R7 word unchanged", {8'h0, word_o}, 32'h123456);

    // R1: after STOP a byte without START is ignored
    send_byte({7'h11, 1'b0}, 1'b0, "R1 no ack without START", 1'b0);
    bus_stop();

    // R2 R9: supply selection
    addr_sel = 2'b10;
    bus_start();
    send_byte({7'h10, 1'b0}, 1'b0, "R9 0x10 refused with supply", 1'b0);
    send_byte(8'h11, 1'b0, "R9 byte after mismatch", 1'b0);
    bus_stop();
    bus_start();
    send_byte({7'h12, 1'b0}, 1'b1, "R2 addr 0x12 supply", 1'b0);
    exp_q.push_back(24'h00FF81);
    send_byte(8'h00, 1'b1, "R6 byte1", 1'b0);
    send_byte(8'hFF, 1'b1, "R6 byte2", 1'b0);
    send_byte(8'h81, 1'b1, "R6 byte3", 1'b0);
    bus_stop();

    // R2 R3: code 11 selects nothing, broadcast still answered
    addr_sel = 2'b11;
    bus_start();
    send_byte({7'h10, 1'b0}, 1'b0, "R2 code 11 selects no pin address", 1'b0);
    bus_stop();
    bus_start();
    send_byte({7'h73, 1'b0}, 1'b1, "R3 broadcast", 1'b0);
    exp_q.push_back(24'hC0FFEE);
    send_byte(8'hC0, 1'b1, "R3 byte1", 1'b0);
    send_byte(8'hFF, 1'b1, "R3 byte2", 1'b0);
    send_byte(8'hEE, 1'b1, "R3 byte3", 1'b0);
    bus_stop();

    // R4: reads refused
    addr_sel = 2'b00;
    bus_start();
    send_byte({7'h10, 1'b1}, 1'b0, "R4 read refused", 1'b0);
    send_byte(8'h22, 1'b0, "R4 byte after read", 1'b0);
    bus_stop();
    bus_start();
    send_byte({7'h73, 1'b1}, 1'b0, "R4 broadcast read refused", 1'b0);
    bus_stop();

    // R8: partial word discarded on STOP and on repeated START
    bus_start();
    send_byte({7'h10, 1'b0}, 1'b1, "R8 addr", 1'b0);
    send_byte(8'hDE, 1'b1, "R8 partial byte1", 1'b0);
    send_byte(8'hAD, 1'b1, "R8 partial byte2", 1'b0);
    bus_stop();
    bus_start();
    send_byte({7'h10, 1'b0}, 1'b1, "R8 addr", 1'b0);
    send_byte(8'hBE, 1'b1, "R8 partial byte1", 1'b0);
    bus_start();
    send_byte({7'h12, 1'b0}, 1'b0, "R8 new address decoded after Sr", 1'b0);
    bus_start();
    send_byte({7'h10, 1'b0}, 1'b1, "R8 addr after Sr", 1'b0);
    exp_q.push_back(24'h010203);
    send_byte(8'h01, 1'b1, "R8 byte1", 1'b0);
    send_byte(8'h02, 1'b1, "R8 byte2", 1'b0);
    send_byte(8'h03, 1'b1, "R8 byte3", 1'b0);
    bus_stop();
    chk(word_o == 24'h010203, "R8 fresh word", {8'h0, word_o}, 32'h010203);

    // R11: one-cycle clock glitches are filtered
    bus_start();
    send_byte({7'h10, 1'b0}, 1'b1, "R11 addr with glitch", 1'b1);
    exp_q.push_back(24'h5AA596);
    send_byte(8'h5A, 1'b1, "R11 byte1 glitch", 1'b1);
    send_byte(8'hA5, 1'b1, "R11 byte2 glitch", 1'b1);
    send_byte(8'h96, 1'b1, "R11 byte3 glitch", 1'b1);
    bus_stop();
    chk(word_o == 24'h5AA596, "R11 word intact", {8'h0, word_o}, 32'h5AA596);

    wait_clks(20);
    chk(exp_q.size() == 0, "R6 all expected words seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule